// File: doc/BRIEF.md
# Tag-Only Set-Associative Cache Model

This block decides whether each memory access would hit or miss in a set-associative cache. It stores no data: main memory is assumed to hold every word. The block keeps only the tags, the valid flags and a true least-recently-used order for each set. It is meant to sit beside a processor model or a traffic generator that needs the hit and miss behaviour of a cache without the cost of its data arrays.

The geometry is set by three parameters: `SETS`, `WAYS` and `BLOCK_WORDS`. Blocks are counted in 16-bit words, so `req_addr` is a word address. Requests arrive on a valid/ready channel and each one returns a single miss flag on a second valid/ready channel. The requester sees `req_ready` low from the moment a request is accepted until its result has been taken. On a miss the result is held back by `MISS_LAT` extra cycles, which models the cost of a refill. Reads and writes are not told apart. Two running counters report how many accesses were accepted and how many of them missed.

Top module: `tagc_model`

## Requirements
- R1: A word address splits into a block offset in its low log2(BLOCK_WORDS) bits, a set index in the next log2(SETS) bits, and a tag in the remaining upper bits. Two addresses that differ only in the offset hit the same block, and an address in the next block maps to the next set.
- R2: The result flag `res_miss` is 1 when the access missed and 0 when it hit.
- R3: Every accepted access updates the tag state. After a miss, the block is present, so a later access to the same block hits unless the block has been evicted since.
- R4: On a miss, an invalid way in the set is filled, the lowest-numbered one first, before any valid way is evicted. A set therefore holds WAYS distinct blocks before its first eviction.
- R5: When every way in the set is valid, a miss replaces the way whose last use is oldest. Every access, hit or miss, makes the way it touched the most recently used.
- R6: For a hit accepted at clock edge k, `res_valid` is high in the cycle right after edge k. For a miss, `res_valid` rises `MISS_LAT` cycles later than it would for a hit.
- R7: `req_ready` is high only when no access is outstanding, and never in the same cycle as `res_valid`. A request presented while `req_ready` is low is not taken and leaves both counters unchanged.
- R8: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_miss` holds its value. After the result is taken, `req_ready` is high in the next cycle.
- R9: `access_count` rises by one for each accepted request, and `miss_count` rises by one for each of those requests that missed. Neither counter changes at any other time.
- R10: After reset every way is invalid, both counters read zero, `req_ready` is high and `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An access request is presented |
| req_ready | output | 1 | The block can accept a request |
| req_addr | input | ADDR_W | Word address of the access |
| res_valid | output | 1 | A result is presented |
| res_ready | input | 1 | The requester takes the result |
| res_miss | output | 1 | 1 = the access missed, 0 = it hit |
| access_count | output | CNT_W | Number of accepted accesses since reset |
| miss_count | output | CNT_W | Number of accepted accesses that missed |

## Verification
A hit result is due in the cycle right after the accepting edge, and a miss result is due `MISS_LAT` cycles after that. The counters move on the accepting edge itself, so they are read in the cycle after the result is taken. The bench drives each request on a falling edge. It then counts falling edges from the acceptance until `res_valid` appears, and compares that count with 0 for a hit or with `MISS_LAT` for a miss. The miss flag, its stability under random back-pressure, and the counters are all sampled on falling edges. Each of them is compared with a behavioural LRU model kept in the bench.

// File: rtl/tagc_pkg.sv
package tagc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_RESP = 2'd2
  } tagc_state_e;

  // Bit width for an index over n items; never below one bit.
  function automatic int width_of(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/tagc_addr_split.sv
module tagc_addr_split #(
  parameter int ADDR_W      = 16,
  parameter int SETS        = 16,
  parameter int BLOCK_WORDS = 2,
  parameter int IDX_W       = 4,
  parameter int TAG_W       = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  localparam int OFF_B = $clog2(BLOCK_WORDS);
  localparam int SET_B = $clog2(SETS);

  logic [ADDR_W-1:0] blk;

  assign blk = addr >> OFF_B;
  assign idx = IDX_W'(blk & ADDR_W'(SETS - 1));
  assign tag = TAG_W'(blk >> SET_B);
endmodule

// File: rtl/tagc_tag_store.sv
module tagc_tag_store #(
  parameter int SETS  = 16,
  parameter int WAYS  = 2,
  parameter int IDX_W = 4,
  parameter int WAY_W = 1,
  parameter int TAG_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  output logic [WAYS-1:0]  hit_vec,
  output logic [WAYS-1:0]  vld_vec
);
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[lk_idx][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[lk_idx][wr_way] <= lk_tag;
  end

  assign vld_vec = vld_q[lk_idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_match
    assign hit_vec[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
  end
endmodule

// File: rtl/tagc_lru_order.sv
module tagc_lru_order #(
  parameter int SETS  = 16,
  parameter int WAYS  = 2,
  parameter int IDX_W = 4,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [WAYS-1:0]  hit_vec,
  input  logic [WAYS-1:0]  vld_vec,
  input  logic             upd_en,
  output logic [WAY_W-1:0] sel_way
);
  // Rank per way: 0 = most recent, WAYS-1 = least recent.
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] hit_way, inv_way, old_way, sel_age;
  logic             inv_found;

  always_comb begin
    hit_way   = '0;
    inv_way   = '0;
    old_way   = '0;
    inv_found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (age_q[lk_idx][w] == WAY_W'(WAYS - 1)) old_way = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_vec[w]) begin
        inv_way   = WAY_W'(w);
        inv_found = 1'b1;
      end
    end
    if (|hit_vec)       sel_way = hit_way;
    else if (inv_found) sel_way = inv_way;
    else                sel_way = old_way;
    sel_age = age_q[lk_idx][sel_way];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (upd_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == sel_way)
          age_q[lk_idx][w] <= '0;
        else if (age_q[lk_idx][w] < sel_age)
          age_q[lk_idx][w] <= age_q[lk_idx][w] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tagc_miss_timer.sv
module tagc_miss_timer #(
  parameter int MISS_LAT = 20,
  parameter int CW       = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= CW'(MISS_LAT - 1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/tagc_model.sv
module tagc_model #(
  parameter int ADDR_W      = 16,
  parameter int SETS        = 16,
  parameter int WAYS        = 2,
  parameter int BLOCK_WORDS = 2,
  parameter int MISS_LAT    = 20,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_miss,
  output logic [CNT_W-1:0]  access_count,
  output logic [CNT_W-1:0]  miss_count
);
  import tagc_pkg::*;

  localparam int IDX_W = width_of(SETS);
  localparam int WAY_W = width_of(WAYS);
  localparam int TAG_W = ADDR_W - $clog2(BLOCK_WORDS) - $clog2(SETS);
  localparam int TMR_W = width_of(MISS_LAT + 1);

  tagc_state_e      state_q;
  logic             miss_q;
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]  hit_vec, vld_vec;
  logic [WAY_W-1:0] sel_way;
  logic             accept, is_miss, fill_done;

  assign req_ready = (state_q == ST_IDLE);
  assign res_valid = (state_q == ST_RESP);
  assign res_miss  = miss_q;
  assign accept    = req_valid && req_ready;
  assign is_miss   = ~|hit_vec;

  tagc_addr_split #(
    .ADDR_W(ADDR_W), .SETS(SETS), .BLOCK_WORDS(BLOCK_WORDS),
    .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_split (
    .addr(req_addr), .idx(lk_idx), .tag(lk_tag)
  );

  tagc_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W), .TAG_W(TAG_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .lk_tag(lk_tag),
    .wr_en(accept), .wr_way(sel_way), .hit_vec(hit_vec), .vld_vec(vld_vec)
  );

  tagc_lru_order #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_lru (
    .clk(clk), .rst_n(rst_n), .lk_idx(lk_idx), .hit_vec(hit_vec),
    .vld_vec(vld_vec), .upd_en(accept), .sel_way(sel_way)
  );

  tagc_miss_timer #(
    .MISS_LAT(MISS_LAT), .CW(TMR_W)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(accept && is_miss), .done(fill_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      miss_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          miss_q  <= is_miss;
          state_q <= is_miss ? ST_FILL : ST_RESP;
        end
        ST_FILL: if (fill_done) state_q <= ST_RESP;
        ST_RESP: if (res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      access_count <= '0;
      miss_count   <= '0;
    end else if (accept) begin
      access_count <= access_count + 1'b1;
      if (is_miss) miss_count <= miss_count + 1'b1;
    end
  end
endmodule

// File: rtl/tagc_model_chk.sv
module tagc_model_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic             res_miss,
  input logic [CNT_W-1:0] access_count,
  input logic [CNT_W-1:0] miss_count
);
  p_ready_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && res_valid));

  p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_miss)));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> req_ready);

  p_hit_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(res_valid) && !res_miss) |-> $past(req_valid && req_ready));

  p_acc_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (access_count == $past(access_count) + 1'b1));

  p_counts_still_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> ($stable(access_count) && $stable(miss_count)));

  p_miss_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    miss_count <= access_count);
endmodule

bind tagc_model tagc_model_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_miss(res_miss),
  .access_count(access_count), .miss_count(miss_count)
);

// File: tb/tb_tagc_model.sv
module tb_tagc_model;
  localparam int SETS = 4, WAYS = 4, BW = 2, AW = 12, LAT = 5, CW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, res_ready = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, res_valid, res_miss;
  logic [CW-1:0] access_count, miss_count;

  always #2 clk = ~clk;

  tagc_model #(.ADDR_W(AW), .SETS(SETS), .WAYS(WAYS), .BLOCK_WORDS(BW),
               .MISS_LAT(LAT), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .res_valid(res_valid), .res_ready(res_ready),
    .res_miss(res_miss), .access_count(access_count), .miss_count(miss_count)
  );

  int checks = 0, fails = 0, cyc = 0, now = 0, exp_acc = 0, exp_mis = 0;
  int  mtag [SETS][WAYS];
  bit  mval [SETS][WAYS];
  int  mstamp [SETS][WAYS];

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R6 watchdog expired: got %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        mval[s][w] = 0; mstamp[s][w] = 0; mtag[s][w] = 0;
      end
    exp_acc = 0; exp_mis = 0;
  endtask

  // Behavioural model: returns 1 on a miss and updates the state.
  function automatic bit model_access(int addr);
    int blk, s, t, v, oldest;
    blk = addr / BW; s = blk % SETS; t = blk / SETS;
    now++;
    for (int w = 0; w < WAYS; w++)
      if (mval[s][w] && mtag[s][w] == t) begin
        mstamp[s][w] = now;
        return 1'b0;
      end
    v = -1;
    for (int w = WAYS - 1; w >= 0; w--) if (!mval[s][w]) v = w;
    if (v < 0) begin
      v = 0; oldest = mstamp[s][0];
      for (int w = 1; w < WAYS; w++)
        if (mstamp[s][w] < oldest) begin v = w; oldest = mstamp[s][w]; end
    end
    mval[s][v] = 1; mtag[s][v] = t; mstamp[s][v] = now;
    return 1'b1;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; res_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "req_ready after reset", int'(req_ready), 1);
    chk(res_valid == 1'b0, "R10", "res_valid after reset", int'(res_valid), 0);
    chk(access_count == 0 && miss_count == 0, "R10", "counters after reset",
        int'(access_count + miss_count), 0);
  endtask

  // dir=1: expected miss flag given explicitly (directed case), else from model.
  task automatic access(int addr, bit dir, bit dir_miss, string req,
                        int stall, bit poke);
    bit exp, mres;
    int lat;
    mres = model_access(addr);
    exp  = dir ? dir_miss : mres;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7", "ready while idle", int'(req_ready), 1);
    req_valid = 1'b1; req_addr = AW'(addr);
    @(negedge clk);
    if (poke) begin
      req_addr = AW'($urandom % 128);    // held while busy: must be ignored (R7)
    end else begin
      req_valid = 1'b0;
    end
    lat = 0;
    while (!res_valid && lat < LAT + 8) begin
      @(negedge clk);
      lat++;
    end
    chk(res_valid == 1'b1, "R6", "result appeared", int'(res_valid), 1);
    chk(res_miss == exp, req, "miss flag", int'(res_miss), int'(exp));
    chk(lat == (exp ? LAT : 0), "R6", "result latency", lat, exp ? LAT : 0);
    exp_acc++;
    if (exp) exp_mis++;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(res_valid == 1'b1 && res_miss == exp, "R8", "held under back-pressure",
          int'({res_valid, res_miss}), int'({1'b1, exp}));
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0; req_valid = 1'b0;
    chk(!res_valid && req_ready, "R8", "ready after result taken",
        int'({res_valid, req_ready}), 1);
    chk(access_count == CW'(exp_acc), "R9", "access_count", int'(access_count), exp_acc);
    chk(miss_count == CW'(exp_mis), "R9", "miss_count", int'(miss_count), exp_mis);
  endtask

  function automatic int set1_addr(int t);
    return (t * SETS + 1) * BW;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R1: word 16 -> block 8, set 0; word 17 same block; word 18 next set.
    access(16, 1, 1, "R1", 0, 0);
    access(17, 1, 0, "R1", 1, 0);
    access(18, 1, 1, "R1", 0, 0);
    access(16, 1, 0, "R3", 0, 1);

    do_reset();
    // R4: four tags fill the four ways of set 1 without eviction.
    for (int t = 1; t <= 4; t++) access(set1_addr(t), 1, 1, "R4", 0, 0);
    for (int t = 1; t <= 4; t++) access(set1_addr(t), 1, 0, "R4", 0, 0);
    // R5: touch tag 1, so tag 2 is oldest; tag 5 evicts it.
    access(set1_addr(1), 1, 0, "R5", 0, 0);
    access(set1_addr(5), 1, 1, "R5", 2, 0);
    access(set1_addr(1), 1, 0, "R5", 0, 0);
    access(set1_addr(2), 1, 1, "R5", 0, 1);   // evicts tag 3
    access(set1_addr(4), 1, 0, "R5", 0, 0);
    access(set1_addr(3), 1, 1, "R5", 0, 0);   // evicts tag 5
    access(set1_addr(5), 1, 1, "R5", 0, 0);

    // Random mix: small address range keeps conflicts frequent (R2 R3 R5).
    for (int n = 0; n < 600; n++)
      access(int'($urandom % 96), 0, 0, "R2", int'($urandom % 3), bit'($urandom % 2));

    summary();
    $finish;
  end
endmodule